// File: doc/BRIEF.md
# Power-On and Hard Reset Sequencer

This block owns the reset of a device and takes requests from two places. One is a dedicated power-on request input. The other is a shared open-drain hard reset pin that this block and outside agents can both pull low. Either request raises the internal reset at once, without waiting for a clock edge. After the request has passed through a synchronizer, the block runs a flow of fixed length.

During the flow the block holds the shared pin low through an output-enable. An outside pull-up returns the pin to high when the block lets go. The block watches the pin for outside assertions only while it is not pulling the pin low itself, plus one masked guard cycle after each release. A power-on request wins over a hard request and restarts the count. A one-bit status output records which kind of flow ran last.

Top module: `rstseq_top`

## Requirements
- R1: Raising `por_in` raises `dev_rst` at once, with no clock edge needed. After the next rising clock edge `hrst_pin_oe` is 1 and `flow_kind` is 0, where 0 means a power-on flow.
- R2: An outside low level on `hrst_pin_in` while the block is idle raises `dev_rst` before any clock edge. This holds even for a pulse shorter than one clock period that ends before the next edge.
- R3: For a hard flow, the first rising edge after the outside assertion sets `hrst_pin_oe` to 1 and `flow_kind` to 1, where 1 means a hard flow. `hrst_pin_oe` and `dev_rst` then stay 1 for exactly HOLD_CYCLES (32) cycles and fall together.
- R4: In a power-on flow, `hrst_pin_oe` and `dev_rst` stay 1 while `por_in` is high. They fall on the rising edge numbered SYNC_STAGES + HOLD_CYCLES (the 34th) after `por_in` falls.
- R5: The cycle right after the pin is released is masked. An outside low level that lasts only within that cycle starts no flow.
- R6: An outside low level held past the masked cycle starts a new hard flow. `dev_rst` rises during the first idle cycle, and `hrst_pin_oe` rises on the following edge.
- R7: Outside activity on the pin while the block drives it goes undetected. It neither lengthens the flow nor starts a second one.
- R8: A power-on request during a hard flow changes `flow_kind` to 0 and restarts the count. The release then happens on the 34th edge after `por_in` falls.
- R9: `flow_kind` keeps its value between flows and changes only when a flow starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_in | input | 1 | Power-on request, active high, asynchronous |
| hrst_pin_in | input | 1 | Level seen on the shared hard reset pin (0 = asserted) |
| hrst_pin_oe | output | 1 | 1 = pull the shared pin low, 0 = high impedance |
| dev_rst | output | 1 | Internal reset for the rest of the device, active high |
| flow_kind | output | 1 | Kind of the last flow: 0 power-on, 1 hard |

## Verification
The bench drives outside pin pulses shorter than a clock period. A design that needed a clock edge to capture them would never start a flow. It measures the release edge of every flow exactly, for both flow kinds, so an off-by-one in the counter or a missing synchronizer stage shows up as a release one cycle early or late. It pulls the pin low inside the drive window, inside the masked guard cycle, and across the guard cycle. A design that kept watching its own pin, or that dropped the guard, would chain extra flows, and a design that masked too long would miss the held assertion. Power-on requests during hard flows check both the priority and the restart of the count.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;

    localparam int unsigned HOLD_CYCLES_DEF = 32;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned NUM_SOURCES     = 2;
    localparam int unsigned SRC_POR         = 0;
    localparam int unsigned SRC_HARD        = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_GUARD = 2'd2
    } seq_state_e;

    typedef enum logic {
        FLOW_POR  = 1'b0,
        FLOW_HARD = 1'b1
    } flow_kind_e;

    typedef struct packed {
        logic hard;
        logic por;
    } req_t;

    function automatic int unsigned cnt_width(input int unsigned hold);
        return $clog2(hold) + 1;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
module rstseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic set_a,
    output logic req_s
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk or posedge set_a) begin
        if (set_a) begin
            stg <= '1;
        end else begin
            stg <= {stg[STAGES-2:0], 1'b0};
        end
    end

    assign req_s = stg[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
`timescale 1ns/1ps
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = HOLD_CYCLES_DEF
) (
    input  logic       clk,
    input  req_t       req,
    output logic       drive,
    output logic       guard,
    output flow_kind_e kind
);
    localparam int unsigned CNT_W = cnt_width(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (req.por) begin
            state <= ST_DRIVE;
            cnt   <= '0;
            kind  <= FLOW_POR;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req.hard) begin
                        state <= ST_DRIVE;
                        cnt   <= '0;
                        kind  <= FLOW_HARD;
                    end
                end
                ST_DRIVE: begin
                    if (cnt == CNT_LAST) begin
                        state <= ST_GUARD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GUARD: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign drive = (state == ST_DRIVE);
    assign guard = (state == ST_GUARD);

    AST_GUARD_LEADS_IDLE: assert property (@(posedge clk) disable iff (req.por)
        guard |=> !guard && !drive || req.hard) else $error("guard too long"); // R5
endmodule

// File: rtl/rstseq_pin.sv
`timescale 1ns/1ps
module rstseq_pin (
    input  logic drive,
    input  logic guard,
    input  logic pin_in,
    output logic pin_oe,
    output logic ext_set
);
    logic monitor_on;

    assign monitor_on = !drive && !guard;
    assign pin_oe     = drive;
    assign ext_set    = monitor_on && !pin_in;
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = HOLD_CYCLES_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic por_in,
    input  logic hrst_pin_in,
    output logic hrst_pin_oe,
    output logic dev_rst,
    output logic flow_kind
);
    logic [NUM_SOURCES-1:0] set_vec;
    logic [NUM_SOURCES-1:0] req_vec;
    req_t       req;
    logic       drive;
    logic       guard;
    logic       ext_set;
    flow_kind_e kind;

    assign set_vec[SRC_POR]  = por_in;
    assign set_vec[SRC_HARD] = ext_set;

    for (genvar g = 0; g < NUM_SOURCES; g++) begin : g_sync
        rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .set_a (set_vec[g]),
            .req_s (req_vec[g])
        );
    end

    assign req.por  = req_vec[SRC_POR];
    assign req.hard = req_vec[SRC_HARD];

    rstseq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk   (clk),
        .req   (req),
        .drive (drive),
        .guard (guard),
        .kind  (kind)
    );

    rstseq_pin u_pin (
        .drive   (drive),
        .guard   (guard),
        .pin_in  (hrst_pin_in),
        .pin_oe  (hrst_pin_oe),
        .ext_set (ext_set)
    );

    assign dev_rst   = req.por || req.hard || drive;
    assign flow_kind = kind;

    logic [15:0] run_len;
    always_ff @(posedge clk) begin
        if (!hrst_pin_oe) begin
            run_len <= '0;
        end else if (run_len != 16'hFFFF) begin
            run_len <= run_len + 16'd1;
        end
    end

    AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (por_in || req.por)
        $fell(hrst_pin_oe) |-> run_len >= 16'(HOLD_CYCLES)) else $error("short drive"); // R3
    AST_POR_TAKES_PIN: assert property (@(posedge clk) disable iff (por_in)
        req.por |=> hrst_pin_oe && flow_kind == FLOW_POR) else $error("por lost"); // R8
    AST_KIND_ONLY_AT_START: assert property (@(posedge clk) disable iff (por_in || req.por)
        !$stable(flow_kind) |-> hrst_pin_oe) else $error("kind moved"); // R9
    AST_NO_SELF_DETECT: assert property (@(posedge clk) disable iff (por_in || req.por)
        $fell(hrst_pin_oe) |-> !req.hard) else $error("self detect"); // R7
    AST_QUIET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (por_in || req.por)
        $fell(hrst_pin_oe) |=> !hrst_pin_oe) else $error("re-drive in guard"); // R5
endmodule

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
    localparam int HOLD = 32;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic por_in;
    logic ext_low;
    logic pin;
    logic oe, dev_rst, kind;
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign pin = !(oe || ext_low);

    rstseq_top #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
        .clk         (clk),
        .por_in      (por_in),
        .hrst_pin_in (pin),
        .hrst_pin_oe (oe),
        .dev_rst     (dev_rst),
        .flow_kind   (kind)
    );

    function automatic int por_release_edge();
        return SYNC + HOLD;
    endfunction

    function automatic int hard_release_edge();
        return HOLD + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic por_flow(input int hi, input string req);
        int ok;
        por_in = 1'b1;
        #1;
        chk("R1 dev_rst async", dev_rst, 1);
        @(negedge clk);
        chk({req, " oe after edge"}, oe, 1);
        chk({req, " kind power-on"}, kind, 0);
        repeat (hi - 1) @(negedge clk);
        por_in = 1'b0;
        ok = 1;
        for (int n = 1; n < por_release_edge(); n++) begin
            @(negedge clk);
            if (!(oe && dev_rst)) ok = 0;
        end
        chk({req, " held to release edge"}, ok, 1);
        @(negedge clk);
        chk({req, " oe released"}, oe, 0);
        chk({req, " dev_rst released"}, dev_rst, 0);
    endtask

    task automatic hard_flow(input int hold, input bit glitch);
        int ok;
        ext_low = 1'b1;
        #1;
        chk("R2 dev_rst async", dev_rst, 1);
        if (hold == 0) ext_low = 1'b0;
        @(negedge clk);
        chk("R3 oe first edge", oe, 1);
        chk("R3 kind hard", kind, 1);
        ok = 1;
        for (int n = 2; n < hard_release_edge(); n++) begin
            if (hold != 0 && n - 1 == hold) ext_low = 1'b0;
            if (glitch && n == HOLD / 2) ext_low = 1'b1;
            if (glitch && n == HOLD / 2 + 4) ext_low = 1'b0;
            @(negedge clk);
            if (!(oe && dev_rst)) ok = 0;
        end
        chk(glitch ? "R7 drive width with inner pulse" : "R3 drive width", ok, 1);
        @(negedge clk);
        chk("R3 oe released", oe, 0);
        chk("R3 dev_rst released", dev_rst, 0);
    endtask

    task automatic idle_gap(input int cycles, input int exp_kind);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R7 idle oe", oe, 0);
            chk("R9 kind kept", kind, exp_kind);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ok;
        int op;
        int last_kind;
        por_in  = 1'b0;
        ext_low = 1'b0;
        void'($urandom(32'd20240917));
        @(negedge clk);
        por_flow(3, "R4");
        idle_gap(3, 0);

        hard_flow(0, 1'b0);
        idle_gap(4, 1);

        // R5: low only inside the guard cycle
        hard_flow(5, 1'b0);
        ext_low = 1'b1;
        #1;
        ext_low = 1'b0;
        idle_gap(4, 1);
        chk("R5 no flow from guard pulse", dev_rst, 0);

        // R6: low held across the guard cycle
        hard_flow(3, 1'b0);
        ext_low = 1'b1;
        @(negedge clk);
        chk("R6 dev_rst in idle cycle", dev_rst, 1);
        chk("R6 oe not yet", oe, 0);
        @(negedge clk);
        chk("R6 oe new flow", oe, 1);
        ext_low = 1'b0;
        ok = 1;
        for (int n = 2; n < hard_release_edge(); n++) begin
            @(negedge clk);
            if (!oe) ok = 0;
        end
        chk("R6 new flow width", ok, 1);
        @(negedge clk);
        chk("R6 new flow released", oe, 0);
        idle_gap(3, 1);

        // R8: power-on during a hard flow
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        repeat (10) @(negedge clk);
        por_flow(2, "R8");
        idle_gap(3, 0);

        last_kind = 0;
        for (int it = 0; it < 40; it++) begin
            op = int'($urandom_range(0, 9));
            if (op < 6) begin
                hard_flow(int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
                last_kind = 1;
            end else if (op < 8) begin
                por_flow(int'($urandom_range(1, 5)), "R4");
                last_kind = 0;
            end else begin
                ext_low = 1'b1;
                #1;
                ext_low = 1'b0;
                repeat (int'($urandom_range(2, 25))) @(negedge clk);
                por_flow(int'($urandom_range(1, 4)), "R8");
                last_kind = 0;
            end
            idle_gap(int'($urandom_range(1, 5)), last_kind);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule